// File: doc/BRIEF.md
# Control-Register Bus Handshake Master

This block sits between a simple host request port and the narrow control-register bus of a PHY. The host presents one request at a time: an operation code, a 16-bit register address, 16-bit write data and a 16-bit mask. The block splits the request into bus phases and runs each phase as a four-phase strobe/acknowledge exchange. It then reports the outcome with a one-cycle completion pulse, the last word read and an error flag.

Every phase starts the same way. The value goes onto the shared data-in field for one full cycle with no strobe raised. The phase's strobe then rises and stays up until acknowledge is seen high. After that the strobe drops, and the block waits for acknowledge to fall again. Data-in does not change during any of this. A phase is one of four kinds: address capture, data capture, read or write.

A read-modify-write runs a complete read, merges the result with the mask and the new bits, and then runs a complete write to the same register. Each wait for acknowledge, whether rising or falling, is bounded by a cycle limit. If a wait reaches the limit, the transaction is abandoned and flagged.

Top module: `crbus_master`

## Requirements
- R1: While reset is low and after its release, all four strobes, data-in, `rsp_done`, `rsp_err` and `rsp_rdata` are zero and `req_ready` is high.
- R2: `req_ready` is high only when no transaction is active. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Opcode 0 is read, 1 is write, 2 is read-modify-write, and 3 behaves as a read.
- R3: Before any strobe rises, data-in already holds the phase value, and it held that value for at least one whole cycle with all strobes low.
- R4: A strobe stays high until acknowledge is sampled high. It is low in the following cycle. Data-in keeps its value until acknowledge is sampled low. At most one strobe is high at a time.
- R5: A read is an address-capture phase with data-in equal to the address, followed by a read phase with data-in equal to zero. The data-out field is sampled on the edge where acknowledge is first seen high during the read strobe, and that value appears on `rsp_rdata`.
- R6: A write is an address-capture phase, then a data-capture phase, then a write phase. The last two carry the write data on data-in.
- R7: A read-modify-write performs the read phases, then the write phases, to the same address. The written value is `(read_value & ~mask) | wdata`, and `rsp_rdata` returns the value read.
- R8: `rsp_done` is a single-cycle pulse in the cycle after acknowledge is sampled low in the final phase. In that cycle data-in is zero and `req_ready` is high.
- R9: If a wait for acknowledge high or low lasts `tmo_limit` consecutive cycles without the awaited level, the transaction aborts. The abort drops all strobes, sets data-in to zero, pulses `rsp_done` and `rsp_err` together, and returns to idle. A limit of 0 acts as a limit of 1.
- R10: A `req_valid` raised while a transaction is active has no effect on that transaction or on any later bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data, or bits to OR in for read-modify-write |
| req_mask | input | 16 | Bits cleared before the OR in read-modify-write |
| tmo_limit | input | 8 | Cycle limit for each acknowledge wait |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Timeout flag, pulses with rsp_done |
| rsp_rdata | output | 16 | Most recent word sampled in a read phase |
| bus_din | output | 16 | Data-in field toward the PHY |
| bus_cap_addr | output | 1 | Address-capture strobe |
| bus_cap_data | output | 1 | Data-capture strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ack | input | 1 | Acknowledge from the PHY |
| bus_dout | input | 16 | Data-out field from the PHY |

## Verification
The hardest case to reach is a timeout in the falling half of a handshake. The strobe has already dropped, the target keeps acknowledge high, and the block must give up while a register value is partly delivered. A limit of zero and the write half of a read-modify-write, which carries a value built from data read earlier in the same transaction, are nearly as hard to reach. The bench drives acknowledge from a target model with a small register file, a separate delay for each handshake edge, and modes that hold acknowledge stuck low or stuck high. A behavioural reference model predicts every strobe, data-in and response value each cycle. Stray `req_valid` pulses are injected during long handshakes.

// File: rtl/crbus_pkg.sv
// Shared types for the control-register bus master.
// Assumes a transaction is a fixed, opcode-selected list of phases.
package crbus_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RMW   = 2'd2,
        OP_SPARE = 2'd3
    } crb_op_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_DATA,
        PH_READ,
        PH_WRITE
    } crb_phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_STROBE,
        SQ_RELEASE
    } crb_step_e;

    // Phase kind at position idx of the list for opcode op.
    function automatic crb_phase_e phase_at(crb_op_e op, logic [2:0] idx);
        crb_phase_e ph;
        ph = PH_ADDR;
        case (op)
            OP_WRITE: begin
                case (idx)
                    3'd1:    ph = PH_DATA;
                    3'd2:    ph = PH_WRITE;
                    default: ph = PH_ADDR;
                endcase
            end
            OP_RMW: begin
                case (idx)
                    3'd1:    ph = PH_READ;
                    3'd3:    ph = PH_DATA;
                    3'd4:    ph = PH_WRITE;
                    default: ph = PH_ADDR;
                endcase
            end
            default: begin
                ph = (idx == 3'd1) ? PH_READ : PH_ADDR;
            end
        endcase
        return ph;
    endfunction

    // Number of phases in the list for opcode op.
    function automatic logic [2:0] phase_count(crb_op_e op);
        logic [2:0] n;
        case (op)
            OP_WRITE: n = 3'd3;
            OP_RMW:   n = 3'd5;
            default:  n = 3'd2;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/crbus_wait_timer.sv
// Per-phase acknowledge wait counter.
// Counts cycles while run is high and clears when clr is high.
// expired is raised during the wait cycle that reaches the limit.
// Assumes the sequencer drives clr as the complement of run.
module crbus_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam int CW = TW + 1;

    logic [TW-1:0] cnt_q;

    // Count waiting cycles, saturating, cleared outside a wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Limit reached when this cycle would be the limit-th without the level.
    always_comb begin
        expired = run && (({1'b0, cnt_q} + CW'(1)) >= {1'b0, limit});
    end

    AST_TMR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && !expired) |=> (cnt_q != '0)); // R9

endmodule

// File: rtl/crbus_rmw_merge.sv
// Read-modify-write merge: clears masked bits of the read word and ORs in new bits.
// Purely combinational. Assumes the read word is stable once the read phase ends.
module crbus_rmw_merge #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] rd_val,
    input  logic [DW-1:0] clr_mask,
    input  logic [DW-1:0] set_bits,
    output logic [DW-1:0] merged
);
    // Merge the read word with the host mask and value.
    always_comb begin
        merged = (rd_val & ~clr_mask) | set_bits;
    end
endmodule

// File: rtl/crbus_sequencer.sv
// Phase sequencer for the control-register bus.
// Walks the phase list of the accepted opcode. Each phase has a setup cycle,
// a strobe held until acknowledge is high, and a release held until acknowledge
// is low. Assumes an external timer flags an over-long wait through tmr_expired.
module crbus_sequencer
    import crbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] req_mask,
    output logic          req_ready,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_dout,
    input  logic          tmr_expired,
    output logic          tmr_run,
    output logic          tmr_clr,
    input  logic [DW-1:0] merged_val,
    output logic [DW-1:0] keep_mask,
    output logic [DW-1:0] new_bits,
    output logic [DW-1:0] bus_din,
    output logic          bus_cap_addr,
    output logic          bus_cap_data,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          rsp_done,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata
);
    crb_step_e     step_q;
    crb_phase_e    phase_q;
    crb_op_e       op_q;
    logic [2:0]    idx_q;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] din_q;
    logic [DW-1:0] rdata_q;
    logic          done_q;
    logic          err_q;

    logic [2:0]    nxt_idx;
    crb_phase_e    nxt_phase;
    logic [DW-1:0] nxt_val;
    logic          last_phase;
    logic          strobe_any;

    // Look ahead to the next phase and the value it places on data-in.
    always_comb begin
        nxt_idx    = idx_q + 3'd1;
        nxt_phase  = phase_at(op_q, nxt_idx);
        last_phase = (nxt_idx == phase_count(op_q));
        case (nxt_phase)
            PH_ADDR: nxt_val = addr_q;
            PH_READ: nxt_val = '0;
            default: nxt_val = (op_q == OP_RMW) ? merged_val : wdata_q;
        endcase
    end

    // The timer runs while a wait has not yet seen its acknowledge level.
    always_comb begin
        tmr_run = ((step_q == SQ_STROBE) && !bus_ack) ||
                  ((step_q == SQ_RELEASE) && bus_ack);
        tmr_clr = !tmr_run;
    end

    // Main sequencing: accept, set up, strobe, release, advance or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= SQ_IDLE;
            phase_q <= PH_ADDR;
            op_q    <= OP_READ;
            idx_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            din_q   <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (step_q)
                SQ_IDLE: begin
                    if (req_valid) begin
                        op_q    <= crb_op_e'(req_op);
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        mask_q  <= req_mask;
                        idx_q   <= '0;
                        phase_q <= PH_ADDR;
                        din_q   <= req_addr;
                        step_q  <= SQ_SETUP;
                    end
                end
                SQ_SETUP: begin
                    step_q <= SQ_STROBE;
                end
                SQ_STROBE: begin
                    if (bus_ack) begin
                        if (phase_q == PH_READ) begin
                            rdata_q <= bus_dout;
                        end
                        step_q <= SQ_RELEASE;
                    end else if (tmr_expired) begin
                        step_q <= SQ_IDLE;
                        din_q  <= '0;
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end
                end
                SQ_RELEASE: begin
                    if (!bus_ack) begin
                        if (last_phase) begin
                            step_q <= SQ_IDLE;
                            din_q  <= '0;
                            done_q <= 1'b1;
                        end else begin
                            idx_q   <= nxt_idx;
                            phase_q <= nxt_phase;
                            din_q   <= nxt_val;
                            step_q  <= SQ_SETUP;
                        end
                    end else if (tmr_expired) begin
                        step_q <= SQ_IDLE;
                        din_q  <= '0;
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end
                end
                default: step_q <= SQ_IDLE;
            endcase
        end
    end

    // Decode the strobe of the current phase and drive the response.
    always_comb begin
        bus_cap_addr = (step_q == SQ_STROBE) && (phase_q == PH_ADDR);
        bus_cap_data = (step_q == SQ_STROBE) && (phase_q == PH_DATA);
        bus_rd       = (step_q == SQ_STROBE) && (phase_q == PH_READ);
        bus_wr       = (step_q == SQ_STROBE) && (phase_q == PH_WRITE);
        strobe_any   = bus_cap_addr || bus_cap_data || bus_rd || bus_wr;
        req_ready    = (step_q == SQ_IDLE);
        bus_din      = din_q;
        rsp_done     = done_q;
        rsp_err      = err_q;
        rsp_rdata    = rdata_q;
        keep_mask    = mask_q;
        new_bits     = wdata_q;
    end

    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_any) |-> $stable(bus_din)); // R3
    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_any && bus_ack) |=> (!strobe_any && $stable(bus_din))); // R4
    AST_ACCEPT_LOADS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && (bus_din == $past(req_addr)))); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ((bus_din == '0) && !strobe_any && req_ready)); // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done); // R9

endmodule

// File: rtl/crbus_master.sv
// Control-register bus handshake master, top level.
// Joins the phase sequencer, the acknowledge wait timer and the
// read-modify-write merge. Assumes one outstanding request at a time.
module crbus_master #(
    parameter int DW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] req_mask,
    input  logic [TW-1:0] tmo_limit,
    output logic          rsp_done,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic [DW-1:0] bus_din,
    output logic          bus_cap_addr,
    output logic          bus_cap_data,
    output logic          bus_rd,
    output logic          bus_wr,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_dout
);
    logic          tmr_expired;
    logic          tmr_run;
    logic          tmr_clr;
    logic [DW-1:0] merged_val;
    logic [DW-1:0] keep_mask;
    logic [DW-1:0] new_bits;

    crbus_sequencer #(.DW(DW)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_op       (req_op),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_mask     (req_mask),
        .req_ready    (req_ready),
        .bus_ack      (bus_ack),
        .bus_dout     (bus_dout),
        .tmr_expired  (tmr_expired),
        .tmr_run      (tmr_run),
        .tmr_clr      (tmr_clr),
        .merged_val   (merged_val),
        .keep_mask    (keep_mask),
        .new_bits     (new_bits),
        .bus_din      (bus_din),
        .bus_cap_addr (bus_cap_addr),
        .bus_cap_data (bus_cap_data),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .rsp_done     (rsp_done),
        .rsp_err      (rsp_err),
        .rsp_rdata    (rsp_rdata)
    );

    crbus_wait_timer #(.TW(TW)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .limit   (tmo_limit),
        .expired (tmr_expired)
    );

    crbus_rmw_merge #(.DW(DW)) mrg_i (
        .rd_val   (rsp_rdata),
        .clr_mask (keep_mask),
        .set_bits (new_bits),
        .merged   (merged_val)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_cap_addr, bus_cap_data, bus_rd, bus_wr})); // R4

endmodule

// File: tb/crbus_master_tb_top.sv
module crbus_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] req_mask = '0;
    logic [7:0]  tmo_limit = 8'd20;
    logic        rsp_done;
    logic        rsp_err;
    logic [15:0] rsp_rdata;
    logic [15:0] bus_din;
    logic        bus_cap_addr;
    logic        bus_cap_data;
    logic        bus_rd;
    logic        bus_wr;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_dout = '0;

    always #4 clk = ~clk;

    crbus_master dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .tmo_limit(tmo_limit), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_din(bus_din), .bus_cap_addr(bus_cap_addr), .bus_cap_data(bus_cap_data),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack(bus_ack), .bus_dout(bus_dout)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Target model: register file, delays and stuck modes.
    logic [15:0] mem [16];
    int d_hi = 1;
    int d_lo = 1;
    bit stuck_hi = 1'b0;
    bit stuck_lo = 1'b0;
    int t_cnt = 0;
    logic [15:0] t_addr = '0;
    logic [15:0] t_data = '0;
    bit prev_sa = 1'b0;
    logic [15:0] prev_din = '0;

    // Reference model state.
    bit m_seen = 1'b0;
    bit m_busy = 1'b0;
    int m_step = 0;
    int m_pi = 0;
    int m_wc = 0;
    int m_op = 0;
    logic [15:0] m_addr = '0;
    logic [15:0] m_wd = '0;
    logic [15:0] m_mask = '0;
    logic [15:0] m_din = '0;
    logic [15:0] m_rdata = '0;
    bit m_done = 1'b0;
    bit m_err = 1'b0;

    // 0 address, 1 data capture, 2 read, 3 write
    function automatic int kind_at(int op, int i);
        if (op == 1) return (i == 0) ? 0 : ((i == 1) ? 1 : 3);
        if (op == 2) begin
            if (i == 1) return 2;
            if (i == 3) return 1;
            if (i == 4) return 3;
            return 0;
        end
        return (i == 1) ? 2 : 0;
    endfunction

    function automatic int nph(int op);
        if (op == 1) return 3;
        if (op == 2) return 5;
        return 2;
    endfunction

    function automatic logic [15:0] mval(int k);
        if (k == 0) return m_addr;
        if (k == 2) return 16'h0000;
        if (m_op == 2) return (m_rdata & ~m_mask) | m_wd;
        return m_wd;
    endfunction

    task automatic m_abort();
        m_busy = 1'b0;
        m_din  = '0;
        m_done = 1'b1;
        m_err  = 1'b1;
    endtask

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        m_seen = 1'b1;
        if (!rst_n) begin
            m_busy = 1'b0; m_step = 0; m_pi = 0; m_wc = 0;
            m_din = '0; m_rdata = '0; m_done = 1'b0; m_err = 1'b0;
        end else begin
            m_done = 1'b0;
            m_err  = 1'b0;
            if (!m_busy) begin
                if (req_valid) begin
                    m_busy = 1'b1;
                    m_op = int'(req_op);
                    m_addr = req_addr; m_wd = req_wdata; m_mask = req_mask;
                    m_pi = 0; m_step = 0; m_din = req_addr;
                end
            end else if (m_step == 0) begin
                m_step = 1; m_wc = 0;
            end else if (m_step == 1) begin
                if (bus_ack) begin
                    if (kind_at(m_op, m_pi) == 2) m_rdata = bus_dout;
                    m_step = 2; m_wc = 0;
                end else if (m_wc + 1 >= int'(tmo_limit)) begin
                    m_abort();
                end else begin
                    m_wc++;
                end
            end else begin
                if (!bus_ack) begin
                    m_pi++; m_wc = 0;
                    if (m_pi == nph(m_op)) begin
                        m_busy = 1'b0; m_din = '0; m_done = 1'b1;
                    end else begin
                        m_step = 0;
                        m_din = mval(kind_at(m_op, m_pi));
                    end
                end else if (m_wc + 1 >= int'(tmo_limit)) begin
                    m_abort();
                end else begin
                    m_wc++;
                end
            end
        end
    end

    // Compare with the model, then act as the target on the falling edge.
    always @(negedge clk) begin
        logic [3:0] exp_s;
        logic [3:0] act_s;
        bit sa;
        int ek;
        if (m_seen) begin
            ek = kind_at(m_op, m_pi);
            exp_s = '0;
            if (m_busy && m_step == 1) exp_s[ek] = 1'b1;
            act_s = {bus_wr, bus_rd, bus_cap_data, bus_cap_addr};
            exp_s = {exp_s[3], exp_s[2], exp_s[1], exp_s[0]};
            chk(act_s == exp_s, "R4 strobes", 32'(act_s), 32'(exp_s));
            chk(bus_din == m_din, "R3 data-in", 32'(bus_din), 32'(m_din));
            chk(req_ready == !m_busy, "R2 ready", 32'(req_ready), 32'(!m_busy));
            chk(rsp_done == m_done, "R8 done", 32'(rsp_done), 32'(m_done));
            chk(rsp_err == m_err, "R9 error", 32'(rsp_err), 32'(m_err));
            chk(rsp_rdata == m_rdata, "R5 read data", 32'(rsp_rdata), 32'(m_rdata));
        end
        sa = bus_cap_addr | bus_cap_data | bus_rd | bus_wr;
        if (rst_n) begin
            if (sa && !prev_sa) chk(bus_din == prev_din, "R3 setup", 32'(bus_din), 32'(prev_din));
            if (!bus_ack) begin
                if (sa && !stuck_hi) begin
                    if (t_cnt >= d_hi) begin
                        if (bus_cap_addr) t_addr = bus_din;
                        if (bus_cap_data) t_data = bus_din;
                        if (bus_wr) mem[t_addr[3:0]] = t_data;
                        if (bus_rd) bus_dout = mem[t_addr[3:0]];
                        bus_ack = 1'b1; t_cnt = 0;
                    end else t_cnt++;
                end else t_cnt = 0;
            end else begin
                if (!sa && !stuck_lo) begin
                    if (t_cnt >= d_lo) begin
                        bus_ack = 1'b0; t_cnt = 0;
                    end else t_cnt++;
                end else t_cnt = 0;
            end
        end else begin
            bus_ack = 1'b0; t_cnt = 0;
        end
        prev_sa = sa;
        prev_din = bus_din;
    end

    task automatic issue(input logic [1:0] op, input logic [15:0] a, input logic [15:0] wd, input logic [15:0] mk);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_mask = mk;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output logic [15:0] rd, output bit er);
        do @(negedge clk); while (!rsp_done);
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    task automatic run_req(input logic [1:0] op, input logic [15:0] a, input logic [15:0] wd,
                           input logic [15:0] mk, output logic [15:0] rd, output bit er);
        issue(op, a, wd, mk);
        wait_done(rd, er);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R8 watchdog", 32'(0), 32'(1));
        finish_up();
    end

    initial begin
        logic [15:0] rd;
        logic [15:0] old;
        logic [15:0] exp;
        bit er;
        for (int i = 0; i < 16; i++) mem[i] = 16'hA500 + 16'(i * 273);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({bus_cap_addr, bus_cap_data, bus_rd, bus_wr} == 4'b0, "R1 strobes", 32'({bus_cap_addr, bus_cap_data, bus_rd, bus_wr}), 32'(0));
        chk(bus_din == 16'h0 && rsp_rdata == 16'h0, "R1 data", 32'({bus_din, rsp_rdata}), 32'(0));
        chk(!rsp_done && !rsp_err && req_ready, "R1 response", 32'({rsp_done, rsp_err, req_ready}), 32'(1));
        rst_n = 1'b1;

        run_req(2'd0, 16'h0003, 16'h0, 16'h0, rd, er);
        chk(rd == mem[3] && !er, "R5 read", 32'(rd), 32'(mem[3]));

        run_req(2'd1, 16'h0005, 16'hBEEF, 16'h0, rd, er);
        chk(mem[5] == 16'hBEEF && !er, "R6 write", 32'(mem[5]), 32'(16'hBEEF));
        run_req(2'd0, 16'h0005, 16'h0, 16'h0, rd, er);
        chk(rd == 16'hBEEF, "R6 readback", 32'(rd), 32'(16'hBEEF));

        d_hi = 0; d_lo = 0;
        old = mem[7];
        exp = (old & ~16'h00F0) | 16'h0050;
        run_req(2'd2, 16'h0007, 16'h0050, 16'h00F0, rd, er);
        chk(rd == old, "R7 read value", 32'(rd), 32'(old));
        chk(mem[7] == exp && !er, "R7 merged", 32'(mem[7]), 32'(exp));

        d_hi = 3; d_lo = 2;
        old = mem[5];
        exp = (old & ~16'hFF00) | 16'h1200;
        run_req(2'd2, 16'h0005, 16'h1200, 16'hFF00, rd, er);
        chk(mem[5] == exp, "R7 merged slow", 32'(mem[5]), 32'(exp));

        run_req(2'd3, 16'h0002, 16'hFFFF, 16'h0, rd, er);
        chk(rd == mem[2] && mem[2] == 16'hA500 + 16'(2 * 273), "R2 opcode 3 reads", 32'(rd), 32'(mem[2]));

        // R10: stray request while busy
        d_hi = 4; d_lo = 4;
        old = mem[10];
        issue(2'd1, 16'h0009, 16'h1234, 16'h0);
        repeat (3) @(negedge clk);
        chk(!req_ready, "R10 busy", 32'(req_ready), 32'(0));
        req_valid = 1'b1; req_op = 2'd1; req_addr = 16'h000A; req_wdata = 16'hDEAD;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        wait_done(rd, er);
        repeat (4) @(negedge clk);
        chk(mem[10] == old, "R10 ignored", 32'(mem[10]), 32'(old));
        chk(mem[9] == 16'h1234, "R10 current kept", 32'(mem[9]), 32'(16'h1234));

        // R9: rising wait never met
        d_hi = 1; d_lo = 1; tmo_limit = 8'd5; stuck_hi = 1'b1;
        old = rsp_rdata;
        run_req(2'd0, 16'h0001, 16'h0, 16'h0, rd, er);
        chk(er == 1'b1, "R9 timeout high", 32'(er), 32'(1));
        chk(rd == old, "R9 rdata kept", 32'(rd), 32'(old));
        stuck_hi = 1'b0;

        // R9: falling wait never met
        tmo_limit = 8'd3; stuck_lo = 1'b1;
        old = mem[4];
        run_req(2'd1, 16'h0004, 16'h7777, 16'h0, rd, er);
        chk(er == 1'b1, "R9 timeout low", 32'(er), 32'(1));
        chk(mem[4] == old, "R9 no write", 32'(mem[4]), 32'(old));
        stuck_lo = 1'b0;
        repeat (5) @(negedge clk);

        // R9: limit zero
        tmo_limit = 8'd0; d_hi = 1;
        run_req(2'd0, 16'h0006, 16'h0, 16'h0, rd, er);
        chk(er == 1'b1, "R9 limit zero", 32'(er), 32'(1));
        repeat (3) @(negedge clk);
        d_hi = 0; d_lo = 0;
        run_req(2'd0, 16'h0006, 16'h0, 16'h0, rd, er);
        chk(!er && rd == mem[6], "R9 limit zero immediate", 32'(rd), 32'(mem[6]));

        tmo_limit = 8'd20; d_hi = 2; d_lo = 1;
        run_req(2'd0, 16'h0009, 16'h0, 16'h0, rd, er);
        chk(!er && rd == 16'h1234, "R5 after abort", 32'(rd), 32'(16'h1234));

        repeat (5) @(negedge clk);
        finish_up();
    end
endmodule